// File: doc/BRIEF.md
# Bus Timestamp Counter Unit

This block keeps a 16-bit timestamp for a CAN-style protocol controller. A 2-bit source select chooses how the count moves. In internal mode it advances through a 4-bit prescaler that is driven by a bit-time tick. In external mode it mirrors a 16-bit timestamp bus that comes from outside the block. In the two remaining modes the count is held at zero.

Software reads the count as a 32-bit word whose upper half is zero. In internal mode, a write strobe on the count clears both the counter and the prescaler. Each start-of-frame pulse copies the current count into a capture register; this is the same for received and transmitted frames.

A sticky flag records every wrap-around, meaning a return of the count from a nonzero value to zero that no write caused. The flag is cleared by writing 1 to it.

Top module: `bus_tstamp_unit`

## Requirements
- R1: `rd_word[31:16]` is always zero and `rd_word[15:0]` shows the current count.
- R2: When `cfg_src` is 2'b01 (internal), the count rises by one on every (`cfg_presc`+1)-th `bit_tick` and does not change on any other cycle.
- R3: When `cfg_src` is 2'b01, a `cnt_wr` pulse sets the count to zero on the next clock and also clears the prescaler. The next increment therefore needs `cfg_presc`+1 more ticks.
- R4: In internal mode, a step from 16'hFFFF to zero sets `wrap_flag`. A return to zero caused by `cnt_wr` leaves `wrap_flag` unchanged.
- R5: When `cfg_src` is 2'b10 (external), the count equals the value that `ext_count` had one clock earlier, and `cnt_wr` has no effect.
- R6: In external mode, a change of the count from a nonzero value to zero sets `wrap_flag`.
- R7: When `cfg_src` is 2'b00 or 2'b11, the count is zero one clock later and `wrap_flag` is never set.
- R8: A `sof_pulse` loads `cap_value` on the next clock with the count that `rd_word` showed during the pulse cycle.
- R9: `wrap_flag` stays set until a `flag_clr` pulse clears it. If a wrap happens in the same cycle as `flag_clr`, the wrap wins.
- R10: After reset the count, the capture register, the prescaler and `wrap_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Source select: 01 internal, 10 external, 00/11 held at zero |
| cfg_presc | input | 4 | Prescaler; divide ratio is value+1 |
| bit_tick | input | 1 | One-cycle bit-time tick |
| ext_count | input | 16 | External timestamp bus |
| cnt_wr | input | 1 | Write strobe to the count register |
| sof_pulse | input | 1 | Start-of-frame event (receive or transmit) |
| flag_clr | input | 1 | Write-1-to-clear strobe for the wrap flag |
| rd_word | output | 32 | Count register read value |
| cap_value | output | 16 | Timestamp captured at the last start of frame |
| wrap_flag | output | 1 | Sticky wrap-around flag |

## Verification
Internal mode is tested with sparse ticks at a prescaler of 3, which separates divide-by-N counting from counting every tick. A write placed in the middle of a prescaler period shows whether the divider is cleared along with the count. A full 65,536-step run with a prescaler of zero checks that a true rollover sets the flag while a write-caused zero does not. External mode is tested with values written on the write strobe, with a fall to zero, and with a clear in the same cycle as a wrap. A long seeded random run then changes mode, ratio, ticks, writes, frames and clears against a bench model.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int CNT_W = 16;
    localparam int PSC_W = 4;
    localparam int RD_W  = 32;

    typedef enum logic [1:0] {
        SRC_HOLD0 = 2'b00,
        SRC_INT   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_HOLD3 = 2'b11
    } tsu_src_e;
endpackage

// File: rtl/tsu_prescaler.sv
module tsu_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    input  logic [PSC_W-1:0] presc,
    output logic             inc
);
    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        inc  = 1'b0;
        if (!run || clr) begin
            st_d.div = '0;
        end else if (tick) begin
            if (st_q.div >= presc) begin
                st_d.div = '0;
                inc      = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.div == '0);
    // R2
    inc_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (tick && run));
endmodule

// File: rtl/tsu_counter.sv
module tsu_counter
    import tsu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tsu_src_e         src,
    input  logic             wr,
    input  logic             inc,
    input  logic [CNT_W-1:0] ext,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        unique case (src)
            SRC_INT: begin
                if (wr) begin
                    st_d.cnt = '0;
                end else if (inc) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    wrap     = (st_q.cnt == CNT_MAX);
                end
            end
            SRC_EXT: begin
                st_d.cnt = ext;
                wrap     = (st_q.cnt != '0) && (ext == '0);
            end
            default: st_d.cnt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_HOLD0 || src == SRC_HOLD3) |=> st_q.cnt == '0);
    // R3
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INT && wr) |=> st_q.cnt == '0);
    // R2
    int_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INT && !wr) |=>
            (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R5
    ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXT) |=> st_q.cnt == $past(ext));
endmodule

// File: rtl/tsu_wrapflag.sv
module tsu_wrapflag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag && !clr) || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);
    // R4
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.flag);
endmodule

// File: rtl/tsu_capture.sv
module tsu_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sof) st_d.cap = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.cap;

    // R8
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> st_q.cap == $past(cnt));
    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(st_q.cap));
endmodule

// File: rtl/bus_tstamp_unit.sv
module bus_tstamp_unit
    import tsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_src,
    input  logic [PSC_W-1:0] cfg_presc,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] ext_count,
    input  logic             cnt_wr,
    input  logic             sof_pulse,
    input  logic             flag_clr,
    output logic [RD_W-1:0]  rd_word,
    output logic [CNT_W-1:0] cap_value,
    output logic             wrap_flag
);
    localparam int PAD_W = RD_W - CNT_W;

    tsu_src_e         src;
    logic             inc;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    assign src = tsu_src_e'(cfg_src);

    tsu_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (src == SRC_INT),
        .clr   (cnt_wr),
        .tick  (bit_tick),
        .presc (cfg_presc),
        .inc   (inc)
    );

    tsu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .wr    (cnt_wr),
        .inc   (inc),
        .ext   (ext_count),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    tsu_wrapflag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .clr   (flag_clr),
        .flag  (wrap_flag)
    );

    tsu_capture #(.CNT_W(CNT_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .sof   (sof_pulse),
        .cnt   (cnt),
        .cap   (cap_value)
    );

    assign rd_word = {{PAD_W{1'b0}}, cnt};

    // R7
    idle_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00 || cfg_src == 2'b11) && !wrap_flag |=> !wrap_flag);
endmodule

// File: tb/bus_tstamp_unit_tb.sv
module bus_tstamp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_src = 2'b00;
    logic [3:0]  cfg_presc = 4'd0;
    logic        bit_tick = 1'b0;
    logic [15:0] ext_count = 16'd0;
    logic        cnt_wr = 1'b0;
    logic        sof_pulse = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] rd_word;
    logic [15:0] cap_value;
    logic        wrap_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] m_cnt = 16'd0;
    logic [3:0]  m_div = 4'd0;
    logic        m_flag = 1'b0;
    logic [15:0] m_cap = 16'd0;

    bus_tstamp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_presc(cfg_presc),
        .bit_tick(bit_tick), .ext_count(ext_count), .cnt_wr(cnt_wr),
        .sof_pulse(sof_pulse), .flag_clr(flag_clr), .rd_word(rd_word),
        .cap_value(cap_value), .wrap_flag(wrap_flag)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Requirement-level model of one clock edge
    task automatic model_edge();
        logic wrapped;
        wrapped = 1'b0;
        if (sof_pulse) m_cap = m_cnt;
        case (cfg_src)
            2'b01: begin
                if (cnt_wr) begin
                    m_cnt = 16'd0; m_div = 4'd0;
                end else if (bit_tick) begin
                    if (m_div >= cfg_presc) begin
                        m_div = 4'd0;
                        wrapped = (m_cnt == 16'hFFFF);
                        m_cnt = m_cnt + 16'd1;
                    end else m_div = m_div + 4'd1;
                end
            end
            2'b10: begin
                wrapped = (m_cnt != 16'd0) && (ext_count == 16'd0);
                m_cnt = ext_count; m_div = 4'd0;
            end
            default: begin m_cnt = 16'd0; m_div = 4'd0; end
        endcase
        m_flag = (m_flag && !flag_clr) || wrapped;
    endtask

    task automatic step(bit cmp);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (cmp) begin
            check("R1 upper half", {16'd0, rd_word[31:16]}, 32'd0);
            case (cfg_src)
                2'b01: check("R2/R3 count", rd_word, {16'd0, m_cnt});
                2'b10: check("R5 count", rd_word, {16'd0, m_cnt});
                default: check("R7 count", rd_word, {16'd0, m_cnt});
            endcase
            check("R8 capture", {16'd0, cap_value}, {16'd0, m_cap});
            check("R4/R6/R9 flag", {31'd0, wrap_flag}, {31'd0, m_flag});
        end
        bit_tick = 1'b0; cnt_wr = 1'b0; sof_pulse = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; step(1'b0);
            step(1'b0);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 count", rd_word, 32'd0);
        check("R10 capture", {16'd0, cap_value}, 32'd0);
        check("R10 flag", {31'd0, wrap_flag}, 32'd0);

        // R2 divide by 4 with sparse ticks
        cfg_src = 2'b01; cfg_presc = 4'd3;
        ticks(8);
        check("R2 after 8 ticks", rd_word, 32'd2);
        ticks(3);
        check("R2 after 11 ticks", rd_word, 32'd2);
        // R3 write in mid-period clears count and divider
        cnt_wr = 1'b1; step(1'b0);
        check("R3 write clears", rd_word, 32'd0);
        ticks(3);
        check("R3 divider cleared", rd_word, 32'd0);
        ticks(1);
        check("R3 full period", rd_word, 32'd1);
        check("R4 write no wrap", {31'd0, wrap_flag}, 32'd0);
        // R8 capture
        sof_pulse = 1'b1; step(1'b0);
        check("R8 capture", {16'd0, cap_value}, 32'd1);

        // R5 external mirror, writes ignored
        cfg_src = 2'b10; ext_count = 16'h1234; step(1'b0);
        check("R5 mirror", rd_word, 32'h1234);
        ext_count = 16'h1235; cnt_wr = 1'b1; step(1'b0);
        check("R5 write ignored", rd_word, 32'h1235);
        check("R5 no flag", {31'd0, wrap_flag}, 32'd0);
        // R6 external wrap
        ext_count = 16'h0000; step(1'b0);
        check("R6 ext wrap flag", {31'd0, wrap_flag}, 32'd1);
        // R9 clear, then set wins over clear
        flag_clr = 1'b1; step(1'b0);
        check("R9 cleared", {31'd0, wrap_flag}, 32'd0);
        ext_count = 16'h0005; step(1'b0);
        ext_count = 16'h0000; flag_clr = 1'b1; step(1'b0);
        check("R9 set wins", {31'd0, wrap_flag}, 32'd1);
        step(1'b0);
        check("R9 sticky", {31'd0, wrap_flag}, 32'd1);
        flag_clr = 1'b1; step(1'b0);

        // R7 hold modes
        ext_count = 16'h0077; step(1'b0);
        cfg_src = 2'b00; ticks(4);
        check("R7 mode 00 zero", rd_word, 32'd0);
        cfg_src = 2'b11; ticks(4);
        check("R7 mode 11 zero", rd_word, 32'd0);
        check("R7 no wrap", {31'd0, wrap_flag}, 32'd0);

        // R4 full rollover with ratio 1
        cfg_src = 2'b01; cfg_presc = 4'd0; cnt_wr = 1'b1; step(1'b0);
        for (int i = 0; i < 65535; i++) begin bit_tick = 1'b1; step(1'b0); end
        check("R4 at max", rd_word, 32'h0000FFFF);
        check("R4 flag before", {31'd0, wrap_flag}, 32'd0);
        bit_tick = 1'b1; step(1'b0);
        check("R4 rollover count", rd_word, 32'd0);
        check("R4 rollover flag", {31'd0, wrap_flag}, 32'd1);

        // Random phase against the model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(63) == 0) cfg_src = 2'($urandom);
            if ($urandom_range(63) == 0) cfg_presc = 4'($urandom);
            bit_tick  = ($urandom_range(3) != 0);
            ext_count = ($urandom_range(15) == 0) ? 16'd0 : 16'($urandom_range(7) + 1);
            cnt_wr    = ($urandom_range(31) == 0);
            sof_pulse = ($urandom_range(15) == 0);
            flag_clr  = ($urandom_range(15) == 0);
            step(1'b1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule